// File: doc/BRIEF.md
# Iterative NLFSR Block Cipher Core

This core enciphers or deciphers one 32-bit block under a 64-bit key. A 32-bit nonlinear feedback shift register holds the block. Each clock cycle it produces one new state bit from a 5-input Boolean function of selected taps, two linear taps and one key bit. A complete operation is 528 such rounds, one per cycle. The decipher direction shifts the register the other way. It walks the key schedule backwards, so it undoes an encipher run under the same key exactly.

The host presents a block, a key and a direction. It then pulses a start request while the core is idle. The core captures all three, raises its busy flag for the 528 rounds and then pulses a done flag for one cycle. The result sits on the output register and stays unchanged until the next accepted start. Key storage, key derivation and any framing around the block belong to the surrounding design.

Top module: `nlfsr_cipher_core`

## Requirements
- R1: A start request sampled while busy is low is accepted: busy is high from the next cycle on, and the block, key and direction are captured at that edge.
- R2: Encipher round r (r = 0..527) computes f = T[idx], where T = 0x3A5C742E and idx = {s31,s26,s20,s9,s1} with s31 as the MSB. The new bit is f XOR s16 XOR s0 XOR key[r mod 64]. The state shifts toward bit 0 and the new bit enters at bit 31.
- R3: Decipher step j (j = 0..527) computes idx from {s30,s25,s19,s8,s0} with the same table. The new bit is T[idx] XOR s15 XOR s31 XOR key[(15 − j) mod 64]. The state shifts toward bit 31 and the new bit enters at bit 0.
- R4: An operation takes exactly 528 round cycles. Done is high in the cycle after the 528th round, which is 528 clock edges after the accepting edge.
- R5: Done is high for exactly one cycle per operation and is never high together with busy.
- R6: While idle, the output keeps the last result until the next accepted start, whatever the data, key and direction inputs do.
- R7: A start request sampled while busy is ignored. The running operation keeps its captured block, key and direction, and it keeps its 528-cycle length.
- R8: Asserting reset at any time clears the state (output 0), busy and done, and abandons any running operation.
- R9: Deciphering the result of an encipher run under the same key returns the original block.
- R10: Changes on the block and key inputs after the accepting edge have no effect on the running operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin an operation, honoured only when idle |
| decrypt_i | input | 1 | Direction: 0 encipher, 1 decipher; captured at start |
| data_i | input | 32 | Input block, captured at start |
| key_i | input | 64 | Key, captured at start |
| busy_o | output | 1 | High while rounds are running |
| done_o | output | 1 | One-cycle pulse after the final round |
| data_o | output | 32 | State register; holds the result while idle |

## Verification
The output is the shift register itself, so a wrong tap, table bit or key bit shows on data_o in the very cycle after the faulty round. The bench follows the register round by round and reports the first diverging cycle. A counter that is off by one, or a start that is wrongly accepted mid-run, moves the done pulse by at least one cycle, and that is caught at the cycle it happens. A wrong key walk in the decipher direction appears at the end of each round trip as a block that does not match the plaintext.

// File: rtl/nlfsr_pkg.sv
package nlfsr_pkg;
  localparam int unsigned BLK_W = 32;
  localparam int unsigned KEY_W = 64;
  localparam int unsigned NLF_IN = 5;
  localparam logic [31:0] NLF_TABLE = 32'h3A5C742E;

  typedef enum logic {
    DIR_ENC = 1'b0,
    DIR_DEC = 1'b1
  } dir_e;

  function automatic logic nlf5(input logic [NLF_IN-1:0] idx);
    return NLF_TABLE[idx];
  endfunction
endpackage

// File: rtl/nlfsr_round.sv
// One round of the register, forward or inverse, chosen at elaboration.
module nlfsr_round
  import nlfsr_pkg::*;
#(
  parameter bit INVERSE = 1'b0
) (
  input  logic [BLK_W-1:0] s_i,
  input  logic             kbit_i,
  output logic [BLK_W-1:0] s_o
);
  logic fb;

  generate
    if (!INVERSE) begin : g_fwd
      always_comb begin
        fb  = nlf5({s_i[31], s_i[26], s_i[20], s_i[9], s_i[1]})
              ^ s_i[16] ^ s_i[0] ^ kbit_i;
        s_o = {fb, s_i[BLK_W-1:1]};
      end
    end else begin : g_inv
      always_comb begin
        fb  = nlf5({s_i[30], s_i[25], s_i[19], s_i[8], s_i[0]})
              ^ s_i[15] ^ s_i[31] ^ kbit_i;
        s_o = {s_i[BLK_W-2:0], fb};
      end
    end
  endgenerate
endmodule

// File: rtl/nlfsr_keysched.sv
// Rotating key register: the active key bit is always at position 0.
module nlfsr_keysched
  import nlfsr_pkg::*;
#(
  parameter int unsigned INV_ROT = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic             dec_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             kbit_o
);
  logic [KEY_W-1:0]   key_q, key_d;
  logic [2*KEY_W-1:0] key_dbl;
  logic [KEY_W-1:0]   key_pre;

  always_comb begin
    key_dbl = {key_i, key_i};
    key_pre = key_dbl[INV_ROT +: KEY_W];
    key_d   = key_q;
    if (load_i) begin
      key_d = dec_i ? key_pre : key_i;
    end else if (adv_i) begin
      key_d = dec_i ? {key_q[KEY_W-2:0], key_q[KEY_W-1]}
                    : {key_q[0], key_q[KEY_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_q <= '0;
    else if (load_i || adv_i) key_q <= key_d;
  end

  assign kbit_o = key_q[0];
endmodule

// File: rtl/nlfsr_ctrl.sv
// Round counter and start/busy/done sequencing.
module nlfsr_ctrl #(
  parameter int unsigned ROUNDS = 528,
  localparam int unsigned CW = $clog2(ROUNDS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic load_o,
  output logic adv_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic          last;

  always_comb begin
    load_o = start_i && !busy_q;
    adv_o  = busy_q;
    last   = busy_q && (cnt_q == CW'(ROUNDS - 1));
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (load_o) begin
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      cnt_d  = cnt_q + CW'(1);
      if (last) busy_d = 1'b0;
    end
    done_d = last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/nlfsr_cipher_core.sv
module nlfsr_cipher_core
  import nlfsr_pkg::*;
#(
  parameter int unsigned ROUNDS = 528,
  localparam int unsigned INV_ROT = (ROUNDS - 1) % KEY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             decrypt_i,
  input  logic [BLK_W-1:0] data_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [BLK_W-1:0] data_o
);
  logic             load, adv, kbit;
  logic             dir_q, dir_d;
  logic [BLK_W-1:0] st_q, st_d, st_fwd, st_inv;

  nlfsr_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .busy_o(busy_o), .done_o(done_o), .load_o(load), .adv_o(adv)
  );

  nlfsr_keysched #(.INV_ROT(INV_ROT)) u_key (
    .clk(clk), .rst_n(rst_n), .load_i(load), .adv_i(adv),
    .dec_i(dir_d), .key_i(key_i), .kbit_o(kbit)
  );

  nlfsr_round #(.INVERSE(1'b0)) u_fwd (.s_i(st_q), .kbit_i(kbit), .s_o(st_fwd));
  nlfsr_round #(.INVERSE(1'b1)) u_inv (.s_i(st_q), .kbit_i(kbit), .s_o(st_inv));

  always_comb begin
    dir_d = load ? decrypt_i : dir_q;
    st_d  = st_q;
    if (load)     st_d = data_i;
    else if (adv) st_d = (dir_q == DIR_DEC) ? st_inv : st_fwd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      dir_q <= DIR_ENC;
    end else begin
      if (load || adv) st_q <= st_d;
      if (load) dir_q <= dir_d;
    end
  end

  assign data_o = st_q;
endmodule

// File: rtl/nlfsr_cipher_chk.sv
module nlfsr_cipher_chk #(
  parameter int unsigned ROUNDS = 528,
  localparam int unsigned LW = $clog2(ROUNDS + 1) + 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic [31:0] data_o
);
  logic [LW-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_q <= '0;
    else if (start_i && !busy_o) len_q <= '0;
    else if (busy_o) len_q <= len_q + LW'(1);
  end

  p_busy_from_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  p_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (len_q == LW'(ROUNDS)));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_not_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(data_o));

  p_busy_needs_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
endmodule

bind nlfsr_cipher_core nlfsr_cipher_chk #(.ROUNDS(ROUNDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i),
  .busy_o(busy_o), .done_o(done_o), .data_o(data_o)
);

// File: tb/tb_nlfsr_cipher_core.sv
module tb_nlfsr_cipher_core;
  localparam int NR = 528;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        decrypt_i = 1'b0;
  logic [31:0] data_i = '0;
  logic [63:0] key_i = '0;
  logic        busy_o, done_o;
  logic [31:0] data_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #2 clk = ~clk;

  nlfsr_cipher_core dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .decrypt_i(decrypt_i),
    .data_i(data_i), .key_i(key_i), .busy_o(busy_o), .done_o(done_o),
    .data_o(data_o)
  );

  function automatic bit tbl(input int idx);
    logic [31:0] t = 32'h3A5C742E;
    return t[idx];
  endfunction

  function automatic logic [31:0] ref_step(input logic [31:0] s, input logic [63:0] k,
                                           input bit dec, input int r);
    int idx; bit nb;
    if (!dec) begin
      idx = 16*s[31] + 8*s[26] + 4*s[20] + 2*s[9] + s[1];
      nb  = tbl(idx) ^ s[16] ^ s[0] ^ k[r % 64];
      return (s >> 1) | (32'(nb) << 31);
    end
    idx = 16*s[30] + 8*s[25] + 4*s[19] + 2*s[8] + s[0];
    nb  = tbl(idx) ^ s[15] ^ s[31] ^ k[((15 - r) % 64 + 64) % 64];
    return (s << 1) | 32'(nb);
  endfunction

  function automatic logic [31:0] ref_run(input logic [31:0] d, input logic [63:0] k, input bit dec);
    logic [31:0] s = d;
    for (int r = 0; r < NR; r++) s = ref_step(s, k, dec, r);
    return s;
  endfunction

  // cycle-accurate behavioural model
  logic [31:0] m_s;
  logic [63:0] m_k;
  bit m_dec, m_busy, m_done;
  int m_r;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s = '0; m_busy = 0; m_done = 0; m_r = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_s = ref_step(m_s, m_k, m_dec, m_r);
        m_r++;
        if (m_r == NR) begin m_busy = 0; m_done = 1; end
      end else if (start_i) begin
        m_s = data_i; m_k = key_i; m_dec = decrypt_i; m_r = 0; m_busy = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_tests++;
      if (busy_o !== m_busy || done_o !== m_done || data_o !== m_s) begin
        n_fail++;
        $display("FAIL %s cycle %0d: busy/done/data act %b/%b/%h exp %b/%b/%h",
                 m_dec ? "R3" : "R2", cyc, busy_o, done_o, data_o, m_busy, m_done, m_s);
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act %h exp %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: act %0d cycles exp below 150000", cyc);
      finish_run();
    end
  end

  // starts an operation, returns result and cycle count
  task automatic run_op(input bit dec, input logic [31:0] d, input logic [63:0] k,
                        output logic [31:0] res, output int n);
    @(negedge clk);
    decrypt_i = dec; data_i = d; key_i = k; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R1 busy after start", 64'(busy_o), 64'd1);
    n = 0;
    while (!done_o) begin @(negedge clk); n++; end
    res = data_o;
  endtask

  initial begin
    logic [31:0] ct, pt, res, held;
    logic [63:0] k;
    int n;

    repeat (3) @(negedge clk);
    chk("R8 reset data", 64'(data_o), 64'd0);
    chk("R8 reset busy", 64'(busy_o), 64'd0);
    chk("R8 reset done", 64'(done_o), 64'd0);
    rst_n = 1'b1;

    // R2 R3 R4 R9: round trips, random and fixed patterns
    for (int i = 0; i < 8; i++) begin
      pt = (i == 0) ? 32'h0 : (i == 1) ? 32'hFFFF_FFFF : $urandom;
      k  = (i == 0) ? 64'h0 : (i == 1) ? '1 : {$urandom, $urandom};
      run_op(1'b0, pt, k, ct, n);
      chk("R4 encipher length", 64'(n), 64'(NR));
      chk("R2 ciphertext", 64'(ct), 64'(ref_run(pt, k, 1'b0)));
      @(negedge clk);
      chk("R5 done one cycle", 64'(done_o), 64'd0);
      run_op(1'b1, ct, k, res, n);
      chk("R4 decipher length", 64'(n), 64'(NR));
      chk("R9 round trip", 64'(res), 64'(pt));
    end

    // R6: idle hold while inputs wiggle
    held = data_o;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      data_i = $urandom; key_i = {$urandom, $urandom}; decrypt_i = i[0];
    end
    chk("R6 hold while idle", 64'(data_o), 64'(held));
    chk("R5 done low while idle", 64'(done_o), 64'd0);

    // R7 R10: start and input changes during a run are ignored
    pt = 32'hC0DE_1234; k = 64'h0123_4567_89AB_CDEF;
    @(negedge clk);
    decrypt_i = 1'b0; data_i = pt; key_i = k; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (100) @(negedge clk);
    data_i = 32'h5555_AAAA; key_i = ~k; decrypt_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 101;
    while (!done_o) begin @(negedge clk); n++; end
    chk("R7 length kept", 64'(n), 64'(NR));
    chk("R10 result uses captured inputs", 64'(data_o), 64'(ref_run(pt, k, 1'b0)));

    // R8: reset in mid-operation
    @(negedge clk);
    data_i = 32'hDEAD_BEEF; decrypt_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (50) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R8 mid-run data", 64'(data_o), 64'd0);
    chk("R8 mid-run busy", 64'(busy_o), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 stays idle", 64'(busy_o), 64'd0);

    finish_run();
  end
endmodule